// File: doc/BRIEF.md
# Dual-Direction Register Mailbox Port

This block lets two processors trade bytes through a small set of registers. A remote master reaches the port over an asynchronous 8-bit parallel bus. That bus has an active-low chip select, active-low read and write strobes, and a 2-bit register index. The local processor reaches the same port through a synchronous register interface that updates on the clock edge.

Each direction has its own bank of three data registers, reached by the same indices 0 to 2. One side writes a bank and the other side reads it. A shared status byte shows a full flag for each of the six registers. A flag is set when its writer stores into the register and cleared when the opposite side reads it.

Register 0 in each direction also acts as a doorbell. When the master writes its register 0, an interrupt flop toward the local side is set. When the local side writes its register 0, the active-low attention line toward the master is pulled low. Each side clears the doorbell aimed at it by writing any value to the status register. The master's strobes are brought into the local clock domain through synchronisers, and bus accesses are acted on when they end.

Top module: `mbox_port`

## Requirements
- R1: After reset all six full flags, the interrupt flop and the attention flop are clear. The control register reads 0, so the port is disabled. `loc_irq` is 0, `ext_attn_n` is 1 and `ext_d_oe` is 0.
- R2: A completed master write to index k (0..2) stores the byte into inbound register k, which the local side reads at `loc_addr` k. It also sets inbound flag k, shown in status bit k.
- R3: A local read (`loc_re`) of inbound register k clears status bit k. A local write to `loc_addr` k (0..2) stores outbound register k and sets status bit 4+k. A completed master read of index k clears status bit 4+k. Status bits 3 and 7 are always 0.
- R4: `ext_d_oe` is 1 only while the port is enabled and both `ext_cs_n` and `ext_rd_n` are low. During such a read, `ext_d_out` shows outbound register `ext_a` (0..2), or the status byte when `ext_a` is 3.
- R5: A completed master write to index 0 sets the inbound interrupt flop. `loc_irq` is 1 exactly when that flop is set and the priority field is nonzero.
- R6: A local write to the status register (`loc_addr` 3) clears the inbound interrupt flop, whatever the data byte.
- R7: A local write to outbound register 0 drives `ext_attn_n` low. A completed master write of any byte to index 3 returns it high.
- R8: While `ext_cs_n` is high, read and write strobes change no register or flag, and `ext_d_oe` stays 0.
- R9: A master write completes at whichever of `ext_wr_n` or `ext_cs_n` rises first. The byte stored is the one held on `ext_d_in` during the strobe.
- R10: While the enable bit is 0, master accesses are ignored and `ext_d_oe` stays 0. `ext_attn_n` is held high even after a local write to outbound register 0.
- R11: The control register sits at `loc_addr` 4. Bit 3 is the port enable and bits 1:0 are the interrupt priority, which also appears on `loc_irq_prio`. All other bits read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loc_addr | input | 3 | Local register index: 0..2 data, 3 status, 4 control |
| loc_we | input | 1 | Local write strobe, one cycle |
| loc_re | input | 1 | Local read strobe, one cycle; clears inbound flags |
| loc_wdata | input | 8 | Local write data |
| loc_rdata | output | 8 | Local read data, combinational from `loc_addr` |
| loc_irq | output | 1 | Interrupt request toward the local processor |
| loc_irq_prio | output | 2 | Programmed interrupt priority |
| ext_cs_n | input | 1 | Master chip select, active low, asynchronous |
| ext_rd_n | input | 1 | Master read strobe, active low, asynchronous |
| ext_wr_n | input | 1 | Master write strobe, active low, asynchronous |
| ext_a | input | 2 | Master register index: 0..2 data, 3 status |
| ext_d_in | input | 8 | Master write data from the shared bus |
| ext_d_out | output | 8 | Data driven toward the master |
| ext_d_oe | output | 1 | Tri-state enable for `ext_d_out` |
| ext_attn_n | output | 1 | Attention line toward the master, active low |

## Verification
The bench builds the port with its default 8-bit data path and two synchroniser stages. This is the shortest legal crossing, so every master access settles within a few local cycles. That short settling time lets a bounded random mix of master and local operations compare each outcome against a byte-level model. Directed cases cover a write ended by chip select before the write strobe, strobes pulsed while chip select is high, and accesses made while the port is disabled.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  localparam int MB_DW   = 8;
  localparam int MB_NREG = 3;

  localparam logic [1:0] EXT_STAT_IDX = 2'd3;
  localparam logic [2:0] LOC_STAT_IDX = 3'd3;
  localparam logic [2:0] LOC_CTRL_IDX = 3'd4;

  localparam int CTRL_EN_BIT = 3;

  typedef struct packed {
    logic       en;
    logic [1:0] prio;
  } mb_ctrl_t;

  // Status byte: inbound flags in the low nibble, outbound flags in the high
  // nibble, the top bit of each nibble fixed at zero.
  function automatic logic [7:0] pack_status(input logic [2:0] inb,
                                             input logic [2:0] outb);
    logic [7:0] s;
    s = '0;
    for (int i = 0; i < 3; i++) begin
      s[i]     = inb[i];
      s[4 + i] = outb[i];
    end
    return s;
  endfunction

  function automatic logic [7:0] pack_ctrl(input mb_ctrl_t c);
    logic [7:0] v;
    v = '0;
    v[CTRL_EN_BIT] = c.en;
    v[1:0]         = c.prio;
    return v;
  endfunction

endpackage

// File: rtl/mbox_sync.sv
module mbox_sync #(
  parameter int         W       = 1,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/mbox_bus_if.sv
module mbox_bus_if #(
  parameter int DW     = 8,
  parameter int AW     = 2,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          port_en,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [AW-1:0] a,
  input  logic [DW-1:0] d_in,
  output logic          wr_evt,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          rd_evt,
  output logic [AW-1:0] rd_addr
);

  logic [2:0] strb_s;
  logic       s_cs_n, s_rd_n, s_wr_n;

  mbox_sync #(.W(3), .STAGES(STAGES), .RST_VAL(3'b111)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({cs_n, rd_n, wr_n}),
    .q     (strb_s)
  );

  assign {s_cs_n, s_rd_n, s_wr_n} = strb_s;

  logic wr_act, rd_act, wr_act_q, rd_act_q;

  assign wr_act = !s_cs_n && !s_wr_n;
  assign rd_act = !s_cs_n && !s_rd_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_act_q <= 1'b0;
      rd_act_q <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      rd_addr  <= '0;
    end else begin
      wr_act_q <= wr_act;
      rd_act_q <= rd_act;
      if (wr_act) begin
        wr_addr <= a;
        wr_data <= d_in;
      end
      if (rd_act) rd_addr <= a;
    end
  end

  // An access completes when the synchronised active condition drops, i.e.
  // at whichever of chip select or the strobe rose first.
  assign wr_evt = wr_act_q && !wr_act && port_en;
  assign rd_evt = rd_act_q && !rd_act && port_en;

  // R8: two synchronised cycles of deselect leave no access to complete
  a_r8_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(s_cs_n) && s_cs_n) |-> (!wr_evt && !rd_evt));

  // R10: a disabled port never completes an access
  a_r10_no_evt_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |-> (!wr_evt && !rd_evt));

endmodule

// File: rtl/mbox_regs.sv
module mbox_regs
  import mbox_pkg::*;
#(
  parameter int DW   = MB_DW,
  parameter int NREG = MB_NREG,
  parameter int LAW  = 3,
  parameter int EAW  = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [LAW-1:0]            loc_addr,
  input  logic                      loc_we,
  input  logic                      loc_re,
  input  logic [DW-1:0]             loc_wdata,
  output logic [DW-1:0]             loc_rdata,
  input  logic                      m_wr_evt,
  input  logic [EAW-1:0]            m_wr_addr,
  input  logic [DW-1:0]             m_wr_data,
  input  logic                      m_rd_evt,
  input  logic [EAW-1:0]            m_rd_addr,
  output logic [NREG-1:0][DW-1:0]   out_data,
  output logic [7:0]                status,
  output mb_ctrl_t                  ctrl,
  output logic                      irq_ff,
  output logic                      attn_ff
);

  logic [NREG-1:0][DW-1:0] in_data;
  logic [NREG-1:0]         in_full, out_full;
  logic [NREG-1:0]         in_set, in_clr, out_set, out_clr;

  for (genvar k = 0; k < NREG; k++) begin : g_dec
    assign in_set[k]  = m_wr_evt && (m_wr_addr == EAW'(k));
    assign in_clr[k]  = loc_re   && (loc_addr  == LAW'(k));
    assign out_set[k] = loc_we   && (loc_addr  == LAW'(k));
    assign out_clr[k] = m_rd_evt && (m_rd_addr == EAW'(k));
  end

  logic irq_set, irq_clr, attn_set, attn_clr, ctrl_we;

  assign irq_set  = in_set[0];
  assign irq_clr  = loc_we && (loc_addr == LOC_STAT_IDX);
  assign attn_set = out_set[0];
  assign attn_clr = m_wr_evt && (m_wr_addr == EXT_STAT_IDX);
  assign ctrl_we  = loc_we && (loc_addr == LOC_CTRL_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_data  <= '0;
      out_data <= '0;
      in_full  <= '0;
      out_full <= '0;
      irq_ff   <= 1'b0;
      attn_ff  <= 1'b0;
      ctrl     <= '0;
    end else begin
      for (int k = 0; k < NREG; k++) begin
        if (in_set[k])  in_data[k]  <= m_wr_data;
        if (out_set[k]) out_data[k] <= loc_wdata;
        // a new write wins over a read ending in the same cycle
        if (in_set[k])       in_full[k] <= 1'b1;
        else if (in_clr[k])  in_full[k] <= 1'b0;
        if (out_set[k])      out_full[k] <= 1'b1;
        else if (out_clr[k]) out_full[k] <= 1'b0;
      end
      if (irq_set)       irq_ff <= 1'b1;
      else if (irq_clr)  irq_ff <= 1'b0;
      if (attn_set)      attn_ff <= 1'b1;
      else if (attn_clr) attn_ff <= 1'b0;
      if (ctrl_we) begin
        ctrl.en   <= loc_wdata[CTRL_EN_BIT];
        ctrl.prio <= loc_wdata[1:0];
      end
    end
  end

  assign status = pack_status(in_full, out_full);

  always_comb begin
    loc_rdata = '0;
    if (loc_addr < LAW'(NREG))          loc_rdata = in_data[loc_addr[EAW-1:0]];
    else if (loc_addr == LOC_STAT_IDX)  loc_rdata = status;
    else if (loc_addr == LOC_CTRL_IDX)  loc_rdata = pack_ctrl(ctrl);
  end

  for (genvar k = 0; k < NREG; k++) begin : g_chk
    // R2: completed master write marks inbound register full
    a_r2_in_full_set: assert property (@(posedge clk) disable iff (!rst_n)
      (m_wr_evt && m_wr_addr == EAW'(k)) |=> status[k]);
    // R3: completed master read empties outbound register unless rewritten
    a_r3_out_full_clr: assert property (@(posedge clk) disable iff (!rst_n)
      (m_rd_evt && m_rd_addr == EAW'(k) && !(loc_we && loc_addr == LAW'(k)))
      |=> !status[4 + k]);
  end

  // R5: master doorbell write raises the inbound interrupt flop
  a_r5_doorbell_set: assert property (@(posedge clk) disable iff (!rst_n)
    (m_wr_evt && m_wr_addr == '0) |=> irq_ff);

  // R6: local status write drops the interrupt flop unless a new doorbell lands
  a_r6_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_we && loc_addr == LOC_STAT_IDX && !(m_wr_evt && m_wr_addr == '0))
    |=> !irq_ff);

  // R7: master status write drops attention unless the local side rings again
  a_r7_attn_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (m_wr_evt && m_wr_addr == EXT_STAT_IDX && !(loc_we && loc_addr == '0))
    |=> !attn_ff);

  // R10: with the port disabled, inbound flags move only by local reads
  a_r10_inbound_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.en && !loc_re) |=> $stable(status[3:0]));

  // R3: status spare bits never set
  a_r3_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (status[3] == 1'b0) && (status[7] == 1'b0));

endmodule

// File: rtl/mbox_port.sv
module mbox_port
  import mbox_pkg::*;
#(
  parameter int DW          = MB_DW,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    loc_addr,
  input  logic          loc_we,
  input  logic          loc_re,
  input  logic [DW-1:0] loc_wdata,
  output logic [DW-1:0] loc_rdata,
  output logic          loc_irq,
  output logic [1:0]    loc_irq_prio,
  input  logic          ext_cs_n,
  input  logic          ext_rd_n,
  input  logic          ext_wr_n,
  input  logic [1:0]    ext_a,
  input  logic [DW-1:0] ext_d_in,
  output logic [DW-1:0] ext_d_out,
  output logic          ext_d_oe,
  output logic          ext_attn_n
);

  localparam int NREG = MB_NREG;
  localparam int EAW  = 2;

  logic                    m_wr_evt, m_rd_evt;
  logic [EAW-1:0]          m_wr_addr, m_rd_addr;
  logic [DW-1:0]           m_wr_data;
  logic [NREG-1:0][DW-1:0] out_data;
  logic [7:0]              status;
  mb_ctrl_t                ctrl;
  logic                    irq_ff, attn_ff;

  mbox_bus_if #(.DW(DW), .AW(EAW), .STAGES(SYNC_STAGES)) u_bus (
    .clk     (clk),
    .rst_n   (rst_n),
    .port_en (ctrl.en),
    .cs_n    (ext_cs_n),
    .rd_n    (ext_rd_n),
    .wr_n    (ext_wr_n),
    .a       (ext_a),
    .d_in    (ext_d_in),
    .wr_evt  (m_wr_evt),
    .wr_addr (m_wr_addr),
    .wr_data (m_wr_data),
    .rd_evt  (m_rd_evt),
    .rd_addr (m_rd_addr)
  );

  mbox_regs #(.DW(DW), .NREG(NREG), .LAW(3), .EAW(EAW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .loc_addr  (loc_addr),
    .loc_we    (loc_we),
    .loc_re    (loc_re),
    .loc_wdata (loc_wdata),
    .loc_rdata (loc_rdata),
    .m_wr_evt  (m_wr_evt),
    .m_wr_addr (m_wr_addr),
    .m_wr_data (m_wr_data),
    .m_rd_evt  (m_rd_evt),
    .m_rd_addr (m_rd_addr),
    .out_data  (out_data),
    .status    (status),
    .ctrl      (ctrl),
    .irq_ff    (irq_ff),
    .attn_ff   (attn_ff)
  );

  always_comb begin
    if (ext_a == EXT_STAT_IDX) ext_d_out = DW'(status);
    else                       ext_d_out = out_data[ext_a];
  end

  assign ext_d_oe     = ctrl.en && !ext_cs_n && !ext_rd_n;
  assign ext_attn_n   = !(ctrl.en && attn_ff);
  assign loc_irq      = irq_ff && (ctrl.prio != 2'b00);
  assign loc_irq_prio = ctrl.prio;

  // R7: a local doorbell on an enabled port pulls attention low next cycle
  a_r7_attn_low: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_we && loc_addr == 3'd0 && ctrl.en) |=> !ext_attn_n);

  // R5: zero priority masks the request
  a_r5_prio_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_irq_prio == 2'b00) |-> !loc_irq);

endmodule

// File: tb/mbox_port_test.sv
module mbox_port_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] loc_addr = '0;
  logic       loc_we = 1'b0, loc_re = 1'b0;
  logic [7:0] loc_wdata = '0;
  logic [7:0] loc_rdata;
  logic       loc_irq;
  logic [1:0] loc_irq_prio;
  logic       ext_cs_n = 1'b1, ext_rd_n = 1'b1, ext_wr_n = 1'b1;
  logic [1:0] ext_a = '0;
  logic [7:0] ext_d_in = '0;
  logic [7:0] ext_d_out;
  logic       ext_d_oe, ext_attn_n;

  always #10 clk = ~clk;

  mbox_port uut (
    .clk(clk), .rst_n(rst_n), .loc_addr(loc_addr), .loc_we(loc_we),
    .loc_re(loc_re), .loc_wdata(loc_wdata), .loc_rdata(loc_rdata),
    .loc_irq(loc_irq), .loc_irq_prio(loc_irq_prio), .ext_cs_n(ext_cs_n),
    .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n), .ext_a(ext_a),
    .ext_d_in(ext_d_in), .ext_d_out(ext_d_out), .ext_d_oe(ext_d_oe),
    .ext_attn_n(ext_attn_n)
  );

  int checks = 0, failures = 0;
  bit done = 0;

  // model
  logic [7:0] m_in [3];
  logic [7:0] m_out [3];
  bit [2:0]   f_in, f_out;
  bit         irq_m, attn_m, en_m;
  logic [1:0] prio_m;

  function automatic logic [7:0] exp_status();
    logic [7:0] v = 8'h00;
    for (int i = 0; i < 3; i++) begin
      if (f_in[i])  v = v | (8'h01 << i);
      if (f_out[i]) v = v | (8'h10 << i);
    end
    return v;
  endfunction

  function automatic logic exp_irq();
    return irq_m && (prio_m != 2'b00);
  endfunction

  function automatic logic exp_attn_n();
    return !(en_m && attn_m);
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic lwr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    loc_addr = a; loc_wdata = d; loc_we = 1'b1;
    @(negedge clk);
    loc_we = 1'b0;
  endtask

  task automatic lrd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    loc_addr = a; loc_re = 1'b1;
    #1 d = loc_rdata;
    @(negedge clk);
    loc_re = 1'b0;
  endtask

  task automatic lpeek(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    loc_addr = a;
    #1 d = loc_rdata;
  endtask

  // write ended by the strobe (cs_first=0) or by chip select (cs_first=1)
  task automatic mwr(input logic [1:0] a, input logic [7:0] d, input bit cs_first);
    @(negedge clk);
    ext_a = a; ext_d_in = d; ext_cs_n = 1'b0;
    @(negedge clk);
    ext_wr_n = 1'b0;
    repeat (4) @(negedge clk);
    if (cs_first) ext_cs_n = 1'b1; else ext_wr_n = 1'b1;
    repeat (4) @(negedge clk);
    ext_cs_n = 1'b1; ext_wr_n = 1'b1;
    ext_d_in = ~d;
    repeat (2) @(negedge clk);
  endtask

  task automatic mrd(input logic [1:0] a, output logic [7:0] d, output logic oe);
    @(negedge clk);
    ext_a = a; ext_cs_n = 1'b0; ext_rd_n = 1'b0;
    repeat (2) @(negedge clk);
    #1 d = ext_d_out; oe = ext_d_oe;
    @(negedge clk);
    ext_rd_n = 1'b1;
    repeat (4) @(negedge clk);
    ext_cs_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic check_side(input string tag);
    logic [7:0] s;
    lpeek(3'd3, s);
    chk({tag, " status R3"}, s, exp_status());
    chk({tag, " irq R5"}, {7'd0, loc_irq}, {7'd0, exp_irq()});
    chk({tag, " attn R7"}, {7'd0, ext_attn_n}, {7'd0, exp_attn_n()});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    logic oe;
    void'($urandom(32'h5EED_2024));
    for (int i = 0; i < 3; i++) begin m_in[i] = 8'h00; m_out[i] = 8'h00; end
    f_in = '0; f_out = '0; irq_m = 0; attn_m = 0; en_m = 0; prio_m = 2'b00;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    #1;
    chk("R1 irq", {7'd0, loc_irq}, 8'h00);
    chk("R1 attn", {7'd0, ext_attn_n}, 8'h01);
    chk("R1 oe", {7'd0, ext_d_oe}, 8'h00);
    lpeek(3'd3, r); chk("R1 status", r, 8'h00);
    lpeek(3'd4, r); chk("R1 ctrl", r, 8'h00);

    // R11 control layout
    lwr(3'd4, 8'hFB);
    en_m = 1; prio_m = 2'b11;
    lpeek(3'd4, r); chk("R11 ctrl readback", r, 8'h0B);
    chk("R11 prio port", {6'd0, loc_irq_prio}, 8'h03);

    // R2/R5 master doorbell write
    mwr(2'd0, 8'hA5, 0);
    m_in[0] = 8'hA5; f_in[0] = 1; irq_m = 1;
    check_side("R2 doorbell");
    // R5 priority zero masks
    lwr(3'd4, 8'h08); prio_m = 2'b00;
    chk("R5 masked irq", {7'd0, loc_irq}, 8'h00);
    lwr(3'd4, 8'h09); prio_m = 2'b01;
    chk("R5 unmasked irq", {7'd0, loc_irq}, 8'h01);
    // R6 status write clears, data ignored
    lwr(3'd3, 8'hFF); irq_m = 0;
    check_side("R6 clear");
    lrd(3'd0, r); chk("R2 inbound data", r, 8'hA5); f_in[0] = 0;
    check_side("R3 inbound read");

    // R9 write ended by chip select first
    mwr(2'd2, 8'h3C, 1);
    m_in[2] = 8'h3C; f_in[2] = 1;
    lpeek(3'd2, r); chk("R9 cs-first data", r, 8'h3C);
    check_side("R9 cs-first");

    // R7 attention
    lwr(3'd0, 8'h11); m_out[0] = 8'h11; f_out[0] = 1; attn_m = 1;
    check_side("R7 ring");
    mrd(2'd3, r, oe);
    chk("R4 oe on read", {7'd0, oe}, 8'h01);
    chk("R4 status over bus", r, exp_status());
    mwr(2'd3, 8'h00, 0); attn_m = 0;
    check_side("R7 master clear");

    // R8 strobes with chip select high
    @(negedge clk);
    ext_a = 2'd1; ext_d_in = 8'h5A; ext_wr_n = 1'b0;
    repeat (4) @(negedge clk);
    ext_wr_n = 1'b1;
    repeat (4) @(negedge clk);
    lpeek(3'd1, r); chk("R8 no write", r, m_in[1]);
    ext_rd_n = 1'b0;
    repeat (3) @(negedge clk);
    #1 chk("R8 oe idle", {7'd0, ext_d_oe}, 8'h00);
    ext_rd_n = 1'b1;
    repeat (4) @(negedge clk);
    check_side("R8 idle");

    // random mix
    for (int it = 0; it < 80; it++) begin
      int op = $urandom_range(0, 5);
      int k  = $urandom_range(0, 2);
      logic [7:0] d = 8'($urandom);
      case (op)
        0: begin
          lwr(3'(k), d); m_out[k] = d; f_out[k] = 1;
          if (k == 0) attn_m = 1;
        end
        1: begin
          lrd(3'(k), r); chk("R2 random local read", r, m_in[k]); f_in[k] = 0;
        end
        2: begin
          int ka = $urandom_range(0, 3);
          mwr(2'(ka), d, bit'($urandom_range(0, 1)));
          if (ka == 3) attn_m = 0;
          else begin
            m_in[ka] = d; f_in[ka] = 1;
            if (ka == 0) irq_m = 1;
          end
        end
        3: begin
          int ka = $urandom_range(0, 3);
          logic [7:0] e = (ka == 3) ? exp_status() : m_out[ka];
          mrd(2'(ka), r, oe);
          chk("R4 random master read", r, e);
          chk("R4 random oe", {7'd0, oe}, 8'h01);
          if (ka < 3) f_out[ka] = 0;
        end
        4: begin
          lwr(3'd3, d); irq_m = 0;
        end
        default: begin
          prio_m = 2'($urandom_range(0, 3));
          lwr(3'd4, {4'h0, 1'b1, 1'b0, prio_m});
        end
      endcase
      check_side("random");
    end

    // R10 disabled port
    lwr(3'd3, 8'h00); irq_m = 0;
    lwr(3'd4, 8'h01); en_m = 0; prio_m = 2'b01;
    mwr(2'd0, 8'hE7, 0);
    lpeek(3'd0, r); chk("R10 ignored write", r, m_in[0]);
    check_side("R10 disabled");
    mrd(2'd3, r, oe);
    chk("R10 oe held low", {7'd0, oe}, 8'h00);
    lwr(3'd0, 8'h22); m_out[0] = 8'h22; f_out[0] = 1; attn_m = 1;
    chk("R10 attn held high", {7'd0, ext_attn_n}, 8'h01);
    check_side("R10 end");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule